// File: doc/BRIEF.md
# Radix-4 Digit-Select Unsigned Multiplier

This block multiplies two unsigned operands, 8 bits each by default, and returns the 16-bit product one clock after the operands arrive. It reads the second operand (the multiplier) as unsigned base-4 digits of two bits each. Each digit picks its partial product directly from the set zero, M, 2M or 3M, where M is the first operand (the multiplicand). The value 3M is formed once and every digit selector uses it. No sign recoding is applied, so every row is non-negative. Each row is shifted to its digit weight. A chain of 3:2 carry-save stages reduces the rows to one sum vector and one carry vector. A single carry-propagate adder then resolves those two vectors into the product.

The surrounding logic presents both operands together with a one-cycle input strobe. The block registers the product and raises an output strobe in the next cycle. A new operand pair may arrive in every cycle, so the block produces one result per clock. When no strobe is present, the product register keeps its last value.

Top module: `r4mul_top`

## Requirements
- R1: While reset is asserted, and right after it is released, `outVld` is 0 and `product` is 0.
- R2: `outVld` is 1 in the cycle after a cycle with `inVld` high, and 0 in the cycle after a cycle with `inVld` low.
- R3: For every pair of unsigned operands, the product presented with `outVld` equals `mcand * mplier`, computed at full width (16 bits by default).
- R4: A multiplier operand of 0, in which every digit is 0, gives a product of 0 for any multiplicand.
- R5: A base-4 digit of value 1 contributes the multiplicand unchanged. Example: `mplier` = 1 gives `product` = `mcand`.
- R6: A digit of value 2 contributes the multiplicand shifted left by one bit. Examples: `mplier` = 2 gives 2·`mcand`, and the pattern 10101010 uses this digit value in every position.
- R7: A digit of value 3 contributes 3·`mcand`. Examples: `mplier` = 3 gives 3·`mcand`, and 255 × 255 gives 65025.
- R8: Digit i occupies multiplier bits [2i+1:2i] and carries weight 4^i. Example: a single nonzero digit in bits [7:6] gives the digit's row shifted left by 6.
- R9: In a cycle with `inVld` low, the operand inputs are ignored and `product` keeps its previous value.
- R10: With `inVld` held high over consecutive cycles, each cycle's result appears in the following cycle, and no operand pair is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inVld | input | 1 | Operand strobe: `mcand` and `mplier` are valid this cycle |
| mcand | input | OP_W (8) | Multiplicand, unsigned |
| mplier | input | OP_W (8) | Multiplier, unsigned; read as base-4 digits |
| outVld | output | 1 | Result strobe, registered |
| product | output | 2·OP_W (16) | Registered unsigned product |

## Verification
A wrong row select for one digit value shows up at the ports in the very next cycle. The error is some multiple of M shifted by the digit's weight, and it appears for every operand pair that contains that digit value in that position. A carry that is dropped or misaligned in the compressor chain gives a wrong product only for particular bit patterns. For that reason every one of the 65536 operand pairs is streamed through back to back and compared one cycle after it is applied. The same streaming run also catches a control fault, such as a late or missing result strobe or a product that changes while no strobe is present, on the first cycle the fault occurs.

// File: rtl/r4mul_pkg.sv
package r4mul_pkg;

  // Width of one multiplier digit; the block is radix-4 by definition.
  localparam int DIGIT_W = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadProd;  // capture the resolved sum into the product register
  } r4mulStrobe_t;

endpackage

// File: rtl/r4mul_ppgen.sv
module r4mul_ppgen
  import r4mul_pkg::*;
#(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W,
  localparam int NUM_DIG = OP_W / DIGIT_W,
  localparam int ROW_W = OP_W + 2
) (
  input  logic [OP_W-1:0]                  mcand,
  input  logic [OP_W-1:0]                  mplier,
  output logic [NUM_DIG-1:0][PROD_W-1:0]   ppRows
);

  logic [ROW_W-1:0] oneM;
  logic [ROW_W-1:0] twoM;
  logic [ROW_W-1:0] threeM;

  // 3M is formed once and used by every digit selector
  assign oneM   = {2'b00, mcand};
  assign twoM   = {1'b0, mcand, 1'b0};
  assign threeM = oneM + twoM;

  for (genvar gi = 0; gi < NUM_DIG; gi++) begin : g_digit
    logic [DIGIT_W-1:0] digit;
    logic [ROW_W-1:0]   rowSel;

    assign digit = mplier[gi*DIGIT_W +: DIGIT_W];

    always_comb begin
      unique case (digit)
        2'd0:    rowSel = '0;
        2'd1:    rowSel = oneM;
        2'd2:    rowSel = twoM;
        default: rowSel = threeM;
      endcase
    end

    // Digit gi has weight 4^gi
    assign ppRows[gi] = {{(PROD_W-ROW_W){1'b0}}, rowSel} << (DIGIT_W * gi);
  end

endmodule

// File: rtl/r4mul_csa.sv
module r4mul_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] inX,
  input  logic [W-1:0] inY,
  input  logic [W-1:0] inZ,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carVec
);

  logic [W-1:0] majority;

  assign sumVec   = inX ^ inY ^ inZ;
  assign majority = (inX & inY) | (inX & inZ) | (inY & inZ);
  // Carries move up one weight; the top carry falls outside the product range
  assign carVec   = {majority[W-2:0], 1'b0};

endmodule

// File: rtl/r4mul_datapath.sv
module r4mul_datapath
  import r4mul_pkg::*;
#(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W,
  localparam int NUM_DIG = OP_W / DIGIT_W,
  localparam int NUM_STG = NUM_DIG - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  r4mulStrobe_t      strobe,
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [PROD_W-1:0] product
);

  logic [NUM_DIG-1:0][PROD_W-1:0] ppRows;
  logic [NUM_STG:0][PROD_W-1:0]   accSum;
  logic [NUM_STG:0][PROD_W-1:0]   accCar;
  logic [PROD_W-1:0]              resolved;

  r4mul_ppgen #(.OP_W(OP_W)) u_ppgen (
    .mcand  (mcand),
    .mplier (mplier),
    .ppRows (ppRows)
  );

  // The first two rows seed the redundant pair
  assign accSum[0] = ppRows[0];
  assign accCar[0] = ppRows[1];

  // Each 3:2 stage folds one further row into the sum/carry pair
  for (genvar gs = 0; gs < NUM_STG; gs++) begin : g_stage
    r4mul_csa #(.W(PROD_W)) u_csa (
      .inX    (accSum[gs]),
      .inY    (accCar[gs]),
      .inZ    (ppRows[gs+2]),
      .sumVec (accSum[gs+1]),
      .carVec (accCar[gs+1])
    );
  end

  // One carry-propagate add at the end
  assign resolved = accSum[NUM_STG] + accCar[NUM_STG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
    end else if (strobe.loadProd) begin
      product <= resolved;
    end
  end

endmodule

// File: rtl/r4mul_ctrl.sv
module r4mul_ctrl
  import r4mul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inVld,
  output r4mulStrobe_t strobe,
  output logic         outVld
);

  always_comb begin
    strobe          = '0;
    strobe.loadProd = inVld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outVld <= 1'b0;
    end else begin
      outVld <= inVld;
    end
  end

endmodule

// File: rtl/r4mul_top.sv
module r4mul_top
  import r4mul_pkg::*;
#(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inVld,
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic              outVld,
  output logic [PROD_W-1:0] product
);

  r4mulStrobe_t strobe;

  r4mul_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inVld  (inVld),
    .strobe (strobe),
    .outVld (outVld)
  );

  r4mul_datapath #(.OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );

endmodule

// File: rtl/r4mul_checker.sv
module r4mul_checker #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inVld,
  input logic [OP_W-1:0]   mcand,
  input logic [OP_W-1:0]   mplier,
  input logic              outVld,
  input logic [PROD_W-1:0] product
);

  logic [PROD_W-1:0] refProd;
  assign refProd = PROD_W'(mcand) * PROD_W'(mplier);

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> outVld);  // R2
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> !outVld);  // R2
  AST_PROD_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    inVld |=> (product == $past(refProd)));  // R3
  AST_ZERO_DIGITS: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && mplier == '0) |=> (product == '0));  // R4
  AST_UNIT_DIGIT: assert property (@(posedge clk) disable iff (!rstN)
    (inVld && mplier == OP_W'(1)) |=> (product == PROD_W'($past(mcand))));  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inVld |=> $stable(product));  // R9

endmodule

bind r4mul_top r4mul_checker #(.OP_W(OP_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inVld   (inVld),
  .mcand   (mcand),
  .mplier  (mplier),
  .outVld  (outVld),
  .product (product)
);

// File: tb/r4mul_top_bench.sv
`timescale 1ns/1ps
module r4mul_top_bench;

  localparam int OP_W = 8;
  localparam int PW = 2 * OP_W;
  localparam int NVEC = 12;

  // {requirement number, mcand, mplier, expected product}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd4,  8'd0,   8'd0,   16'd0},      // R4
    {8'd4,  8'd173, 8'd0,   16'd0},      // R4
    {8'd5,  8'd173, 8'd1,   16'd173},    // R5
    {8'd6,  8'd173, 8'd2,   16'd346},    // R6
    {8'd7,  8'd173, 8'd3,   16'd519},    // R7
    {8'd7,  8'd255, 8'd255, 16'd65025},  // R7
    {8'd3,  8'd169, 8'd201, 16'd33969},  // R3
    {8'd8,  8'd1,   8'd64,  16'd64},     // R8
    {8'd8,  8'd7,   8'd192, 16'd1344},   // R8
    {8'd8,  8'd200, 8'd12,  16'd2400},   // R8
    {8'd6,  8'd255, 8'd170, 16'd43350},  // R6
    {8'd3,  8'd128, 8'd255, 16'd32640}   // R3
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inVld = 1'b0;
  logic [OP_W-1:0] mcand = '0;
  logic [OP_W-1:0] mplier = '0;
  logic          outVld;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  r4mul_top #(.OP_W(OP_W)) u_r4mul_top (
    .clk     (clk),
    .rstN    (rstN),
    .inVld   (inVld),
    .mcand   (mcand),
    .mplier  (mplier),
    .outVld  (outVld),
    .product (product)
  );

  task automatic check(input int req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual running expected finished");
    finishRun();
  end

  initial begin
    logic [PW-1:0] held;
    logic [OP_W-1:0] prevA;
    logic [OP_W-1:0] prevB;
    prevA = '0;
    prevB = '0;

    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check(1, "outVld in reset", PW'(outVld), '0);
    check(1, "product in reset", product, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "outVld after reset", PW'(outVld), '0);
    check(1, "product after reset", product, '0);

    // Vector table: one operation each, result one cycle later
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      inVld  = 1'b1;
      mcand  = VEC[v][31:24];
      mplier = VEC[v][23:16];
      @(negedge clk);
      inVld = 1'b0;
      check(2, "outVld after strobe", PW'(outVld), PW'(1));
      check(int'(VEC[v][39:32]), "table product", product, VEC[v][15:0]);
    end

    // R2 and R9: idle cycle ignores operands and holds the product
    held = product;
    mcand  = 8'd99;
    mplier = 8'd77;
    @(negedge clk);
    check(2, "outVld without strobe", PW'(outVld), '0);
    check(9, "product held while idle", product, held);
    @(negedge clk);
    check(9, "product held second idle", product, held);

    // R3 and R10: all operand pairs streamed back to back
    for (int k = 0; k <= 65536; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check(10, "stream outVld", PW'(outVld), PW'(1));
        check(3, "stream product", product, PW'(prevA) * PW'(prevB));
      end
      if (k < 65536) begin
        inVld  = 1'b1;
        mcand  = OP_W'(k >> OP_W);
        mplier = OP_W'(k);
        prevA  = mcand;
        prevB  = mplier;
      end else begin
        inVld = 1'b0;
      end
    end
    @(negedge clk);
    check(2, "outVld drops after stream", PW'(outVld), '0);

    // R1: reset in the middle of operation clears both outputs
    inVld  = 1'b1;
    mcand  = 8'd255;
    mplier = 8'd255;
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(1, "outVld on mid-run reset", PW'(outVld), '0);
    check(1, "product on mid-run reset", product, '0);
    inVld = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, "product after mid-run reset", product, '0);

    finishRun();
  end

endmodule